// File: doc/BRIEF.md
# Programmable Interval Timer Counter Channel

This block is a single down-counting channel of a three-channel interval timer. The counter advances only on cycles where a one-clock-wide tick enable is high, and that tick runs at the timer's input rate. Software loads an initial value and an operating mode in one strobe. A gate input either enables counting (it is a level) or restarts the period (it is a rising edge). The channel drives its current count and an OUT level continuously. Modes 0, 1, 4 and 5 run once per load or trigger. Mode 2 is a periodic rate generator. Mode 3 produces a square wave.

An initial value of zero stands for a full 2^CNT_W-tick period. In modes 1 and 5 the count waits after a load until the gate rises. A channel-index parameter sets which gate level the edge detector assumes at reset: high for channels 0 and 1, low for channel 2. BCD counting, the null-count flag and interrupt routing are not part of this block.

Top module: `pit_chan`

## Requirements
- R1: After reset the channel is unprogrammed. count_o reads 0, out_o reads 1, and ticks leave both unchanged until the first load.
- R2: A load cycle makes count_o show load_val_i on the next cycle. In mode 3, bit 0 of that value is cleared. A value of 0 acts as 65536 ticks, so the first counting tick shows 0xFFFF (0xFFFE in mode 3).
- R3: In modes 0, 1, 4 and 5, each counting tick lowers the count by one. The count wraps from 0 to 0xFFFF and is never reloaded. Without a load, a tick or a gate rising edge, the count does not change.
- R4: Mode 0 (load_mode_i = 0) drives out_o low after a load. out_o goes high on the tick that takes the count from 1 to 0 and stays high until the next load.
- R5: Mode 2 (code 2) lowers the count by one per tick. The tick that finds the count at 1 reloads the initial value. out_o is low exactly while the count is 1.
- R6: Mode 3 (code 3) lowers the count by two per tick. The tick that finds the count at 2 reloads the even initial value and inverts out_o. out_o is high for the first half-period after a load.
- R7: In modes 0, 2, 3 and 4, a low gate_i stops counting. In modes 1 and 5 the gate level has no effect on counting.
- R8: In modes 1 and 5 (codes 1 and 5), a load holds the count at its initial value with out_o high until a gate rising edge starts counting. In mode 1, out_o is low from that edge until the count reaches 0, and then high.
- R9: A gate rising edge in modes 1, 2, 3 and 5 restarts the period from the initial value, and in mode 3 it sets out_o high. In modes 0 and 4 a rising edge does not restart the count.
- R10: In modes 4 and 5 (codes 4 and 5), out_o is high except from the tick that takes the count from 1 to 0 until the next counting tick, where it is low. This happens once per load or trigger.
- R11: With the default ALIAS_HI = 1, mode codes 6 and 7 behave as modes 2 and 3.
- R12: A load takes precedence over a gate edge in the same cycle, and a gate restart takes precedence over a tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle count enable at the timer input rate |
| gate_i | input | 1 | Gate: enable level or retrigger edge |
| load_i | input | 1 | Load strobe for mode and initial value |
| load_mode_i | input | 3 | Operating mode code 0..7 |
| load_val_i | input | CNT_W (16) | Initial count value; 0 means full range |
| count_o | output | CNT_W (16) | Current count |
| out_o | output | 1 | Channel OUT level |

## Verification
On every cycle, the bound checker confirms four things: the value shown after a load, that the count does not move without a cause, that the count stays even in square-wave mode, and that the mode-0 OUT stays high until the next load once it has risen. It also confirms the unprogrammed state stays frozen. The bench scenarios are the only evidence for the exact cycle of each OUT transition, reload at the end of a period in modes 2 and 3, the gate-triggered start in modes 1 and 5, and which of load, gate restart and tick wins when they coincide.

// File: rtl/pit_chan_pkg.sv
package pit_chan_pkg;

   typedef enum logic [2:0] {
      M_TERM    = 3'd0,
      M_ONESHOT = 3'd1,
      M_RATE    = 3'd2,
      M_SQUARE  = 3'd3,
      M_SWSTB   = 3'd4,
      M_HWSTB   = 3'd5,
      M_IDLE    = 3'd7
   } mode_e;

   // modes in which a gate rising edge restarts the period
   function automatic logic is_retrig(input mode_e m);
      return (m == M_ONESHOT) || (m == M_RATE) || (m == M_SQUARE) || (m == M_HWSTB);
   endfunction

   // modes in which a low gate level suspends counting
   function automatic logic is_gated(input mode_e m);
      return (m == M_TERM) || (m == M_RATE) || (m == M_SQUARE) || (m == M_SWSTB);
   endfunction

   // modes that wait for a gate edge after a load
   function automatic logic is_hw_start(input mode_e m);
      return (m == M_ONESHOT) || (m == M_HWSTB);
   endfunction

endpackage

// File: rtl/pit_gate_edge.sv
module pit_gate_edge #(
   parameter logic RST_LVL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic gate_i,
   output logic rise_o
);

   logic gate_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) gate_q <= RST_LVL;
      else        gate_q <= gate_i;
   end

   assign rise_o = gate_i & ~gate_q;

endmodule

// File: rtl/pit_mode_decode.sv
module pit_mode_decode
   import pit_chan_pkg::*;
#(
   parameter bit ALIAS_HI = 1'b1
) (
   input  logic [2:0] code_i,
   output mode_e      mode_o,
   output logic       valid_o
);

   logic high_code;
   assign high_code = code_i[2] & code_i[1];

   generate
      if (ALIAS_HI) begin : g_alias
         assign mode_o  = high_code ? mode_e'({1'b0, code_i[1:0]}) : mode_e'(code_i);
         assign valid_o = 1'b1;
      end else begin : g_reject
         assign mode_o  = high_code ? M_IDLE : mode_e'(code_i);
         assign valid_o = ~high_code;
      end
   endgenerate

endmodule

// File: rtl/pit_count_core.sv
module pit_count_core
   import pit_chan_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic             ld_ok_i,
   input  mode_e            ld_mode_i,
   input  logic [CNT_W-1:0] ld_val_i,
   input  logic             rise_i,
   input  logic             tick_i,
   input  logic             gate_i,
   output mode_e            mode_o,
   output logic [CNT_W-1:0] cnt_o,
   output logic             run_o,
   output logic             fired_o,
   output logic             strobe_o,
   output logic             phase_o
);

   localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);
   localparam logic [CNT_W-1:0] TWO       = CNT_W'(2);
   localparam logic [CNT_W-1:0] EVEN_MASK = ~ONE;

   mode_e            mode_q;
   logic [CNT_W-1:0] init_q, cnt_q;
   logic             run_q, fired_q, strobe_q, phase_q;
   logic             step_en, restart;
   logic [CNT_W-1:0] restart_val, load_start;

   assign restart     = rise_i & is_retrig(mode_q);
   assign step_en     = tick_i & run_q & (gate_i | ~is_gated(mode_q));
   assign restart_val = (mode_q == M_SQUARE) ? (init_q & EVEN_MASK) : init_q;
   assign load_start  = (ld_mode_i == M_SQUARE) ? (ld_val_i & EVEN_MASK) : ld_val_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q   <= M_IDLE;
         init_q   <= '0;
         cnt_q    <= '0;
         run_q    <= 1'b0;
         fired_q  <= 1'b0;
         strobe_q <= 1'b0;
         phase_q  <= 1'b1;
      end else if (load_i && ld_ok_i) begin
         mode_q   <= ld_mode_i;
         init_q   <= ld_val_i;
         cnt_q    <= load_start;
         run_q    <= ~is_hw_start(ld_mode_i);
         fired_q  <= 1'b0;
         strobe_q <= 1'b0;
         phase_q  <= 1'b1;
      end else if (restart) begin
         cnt_q    <= restart_val;
         run_q    <= 1'b1;
         fired_q  <= 1'b0;
         strobe_q <= 1'b0;
         phase_q  <= 1'b1;
      end else if (step_en) begin
         case (mode_q)
            M_RATE: begin
               cnt_q <= (cnt_q == ONE) ? init_q : cnt_q - ONE;
            end
            M_SQUARE: begin
               if (cnt_q == TWO) begin
                  cnt_q   <= init_q & EVEN_MASK;
                  phase_q <= ~phase_q;
               end else begin
                  cnt_q   <= cnt_q - TWO;
               end
            end
            M_IDLE: begin
               cnt_q <= cnt_q;
            end
            default: begin
               cnt_q    <= cnt_q - ONE;
               strobe_q <= (cnt_q == ONE) & ~fired_q;
               if (cnt_q == ONE) fired_q <= 1'b1;
            end
         endcase
      end
   end

   assign mode_o   = mode_q;
   assign cnt_o    = cnt_q;
   assign run_o    = run_q;
   assign fired_o  = fired_q;
   assign strobe_o = strobe_q;
   assign phase_o  = phase_q;

endmodule

// File: rtl/pit_out_decode.sv
module pit_out_decode
   import pit_chan_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  mode_e            mode_i,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic             run_i,
   input  logic             fired_i,
   input  logic             strobe_i,
   input  logic             phase_i,
   output logic             out_o
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   always_comb begin
      case (mode_i)
         M_TERM:    out_o = fired_i;
         M_ONESHOT: out_o = fired_i | ~run_i;
         M_RATE:    out_o = (cnt_i != ONE);
         M_SQUARE:  out_o = phase_i;
         M_SWSTB,
         M_HWSTB:   out_o = ~strobe_i;
         default:   out_o = 1'b1;
      endcase
   end

endmodule

// File: rtl/pit_chan.sv
module pit_chan
   import pit_chan_pkg::*;
#(
   parameter int CNT_W    = 16,
   parameter int CHAN_IDX = 0,
   parameter bit ALIAS_HI = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             gate_i,
   input  logic             load_i,
   input  logic [2:0]       load_mode_i,
   input  logic [CNT_W-1:0] load_val_i,
   output logic [CNT_W-1:0] count_o,
   output logic             out_o
);

   localparam logic GATE_RST = (CHAN_IDX != 2);

   generate
      if (CNT_W < 4) begin : g_bad_width
         $error("pit_chan: CNT_W must be at least 4");
      end
      if (CHAN_IDX < 0 || CHAN_IDX > 2) begin : g_bad_chan
         $error("pit_chan: CHAN_IDX must be 0, 1 or 2");
      end
   endgenerate

   logic             rise, ld_ok, run, fired, strobe, phase;
   mode_e            ld_mode, mode;
   logic [CNT_W-1:0] cnt;

   pit_gate_edge #(.RST_LVL(GATE_RST)) edge_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .gate_i (gate_i),
      .rise_o (rise)
   );

   pit_mode_decode #(.ALIAS_HI(ALIAS_HI)) dec_i (
      .code_i  (load_mode_i),
      .mode_o  (ld_mode),
      .valid_o (ld_ok)
   );

   pit_count_core #(.CNT_W(CNT_W)) core_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (load_i),
      .ld_ok_i   (ld_ok),
      .ld_mode_i (ld_mode),
      .ld_val_i  (load_val_i),
      .rise_i    (rise),
      .tick_i    (tick_i),
      .gate_i    (gate_i),
      .mode_o    (mode),
      .cnt_o     (cnt),
      .run_o     (run),
      .fired_o   (fired),
      .strobe_o  (strobe),
      .phase_o   (phase)
   );

   pit_out_decode #(.CNT_W(CNT_W)) outd_i (
      .mode_i   (mode),
      .cnt_i    (cnt),
      .run_i    (run),
      .fired_i  (fired),
      .strobe_i (strobe),
      .phase_i  (phase),
      .out_o    (out_o)
   );

   assign count_o = cnt;

endmodule

// File: rtl/pit_chan_chk.sv
module pit_chan_chk #(
   parameter int CNT_W    = 16,
   parameter int CHAN_IDX = 0
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick_i,
   input logic             gate_i,
   input logic             load_i,
   input logic [2:0]       load_mode_i,
   input logic [CNT_W-1:0] load_val_i,
   input logic [CNT_W-1:0] count_o,
   input logic             out_o
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [2:0] mode_t;
   logic       gate_p, seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_t <= 3'd7;
         gate_p <= (CHAN_IDX != 2);
         seen   <= 1'b0;
      end else begin
         gate_p <= gate_i;
         seen   <= 1'b1;
         if (load_i) mode_t <= (load_mode_i >= 3'd6) ? (load_mode_i - 3'd4) : load_mode_i;
      end
   end

   AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_t == 3'd7) |-> (count_o == '0 && out_o)) else $error("idle state moved"); // R1

   AST_LOAD_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && load_mode_i != 3'd3 && load_mode_i != 3'd7) |=> (count_o == $past(load_val_i)))
      else $error("loaded value not shown"); // R2

   AST_LOAD_SQUARE: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && (load_mode_i == 3'd3 || load_mode_i == 3'd7)) |=> (count_o == ($past(load_val_i) & ~ONE)))
      else $error("square load not even"); // R2

   AST_NO_SPONTANEOUS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && !load_i && !tick_i && !(gate_i && !gate_p)) |=> $stable(count_o))
      else $error("count moved without cause"); // R3

   AST_TERM_LOW_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && load_mode_i == 3'd0) |=> !out_o) else $error("mode0 out not low"); // R4

   AST_TERM_OUT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_t == 3'd0 && out_o && !load_i) |=> out_o) else $error("mode0 out fell"); // R4

   AST_SQUARE_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_t == 3'd3) |-> !count_o[0]) else $error("square count odd"); // R6

endmodule

bind pit_chan pit_chan_chk #(.CNT_W(CNT_W), .CHAN_IDX(CHAN_IDX)) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .tick_i      (tick_i),
   .gate_i      (gate_i),
   .load_i      (load_i),
   .load_mode_i (load_mode_i),
   .load_val_i  (load_val_i),
   .count_o     (count_o),
   .out_o       (out_o)
);

// File: tb/pit_chan_tb_top.sv
module pit_chan_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_i = 1'b0;
   logic        gate_i = 1'b1;
   logic        load_i = 1'b0;
   logic [2:0]  load_mode_i = 3'd0;
   logic [15:0] load_val_i = 16'd0;
   logic [15:0] count_o;
   logic        out_o;

   typedef struct {
      logic [15:0] cnt;
      logic        out;
      string       tag;
   } exp_t;

   exp_t exp_q[$];
   int   n_checks = 0;
   int   n_fail = 0;
   logic g_cur = 1'b1;
   logic done = 1'b0;

   always #10 clk = ~clk;

   pit_chan #(.CNT_W(16), .CHAN_IDX(0), .ALIAS_HI(1'b1)) dut_i (
      .clk (clk), .rst_n (rst_n), .tick_i (tick_i), .gate_i (gate_i),
      .load_i (load_i), .load_mode_i (load_mode_i), .load_val_i (load_val_i),
      .count_o (count_o), .out_o (out_o)
   );

   // monitor: compare queued expectations away from the active edge
   always @(negedge clk) begin
      if (exp_q.size() > 0) begin
         exp_t e;
         e = exp_q.pop_front();
         n_checks++;
         if (count_o !== e.cnt || out_o !== e.out) begin
            n_fail++;
            $display("FAIL %s: count=%h out=%b expected count=%h out=%b",
                     e.tag, count_o, out_o, e.cnt, e.out);
         end
      end
   end

   task automatic step(input logic t, input logic g, input logic l,
                       input logic [2:0] m, input logic [15:0] v);
      @(negedge clk);
      tick_i = t; gate_i = g; load_i = l; load_mode_i = m; load_val_i = v;
      g_cur = g;
      @(posedge clk);
      #1;
      tick_i = 1'b0; load_i = 1'b0;
   endtask

   task automatic expect_out(input logic [15:0] c, input logic o, input string tag);
      exp_t e;
      e.cnt = c; e.out = o; e.tag = tag;
      exp_q.push_back(e);
   endtask

   task automatic ld(input logic [2:0] m, input logic [15:0] v);
      step(1'b0, g_cur, 1'b1, m, v);
   endtask

   task automatic tk(input int n);
      for (int i = 0; i < n; i++) step(1'b1, g_cur, 1'b0, 3'd0, 16'd0);
   endtask

   task automatic gt(input logic g, input logic t);
      step(t, g, 1'b0, 3'd0, 16'd0);
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1: reset and unprogrammed state
      gt(1'b1, 1'b0); expect_out(16'h0000, 1'b1, "R1 reset");
      tk(3);          expect_out(16'h0000, 1'b1, "R1 idle ignores ticks");
      // R2, R3, R4: mode 0
      ld(3'd0, 16'd5); expect_out(16'd5, 1'b0, "R2/R4 load mode0");
      tk(4);           expect_out(16'd1, 1'b0, "R3 count down");
      tk(1);           expect_out(16'd0, 1'b1, "R4 out rises at zero");
      tk(1);           expect_out(16'hFFFF, 1'b1, "R3 wrap no reload");
      gt(1'b1, 1'b0);  expect_out(16'hFFFF, 1'b1, "R3 hold without tick");
      // R7: gate pause in mode 0; R9: no restart in mode 0
      ld(3'd0, 16'd10);
      gt(1'b0, 1'b1); gt(1'b0, 1'b1); gt(1'b0, 1'b1);
      expect_out(16'd10, 1'b0, "R7 gate low pauses mode0");
      gt(1'b1, 1'b1); tk(1);
      expect_out(16'd8, 1'b0, "R9 mode0 edge no restart");
      // R5: mode 2
      ld(3'd2, 16'd3); tk(2); expect_out(16'd1, 1'b0, "R5 out low at one");
      tk(1);                  expect_out(16'd3, 1'b1, "R5 reload");
      // R6: mode 3 with odd value
      ld(3'd3, 16'd5); expect_out(16'd4, 1'b1, "R6 odd rounded down");
      tk(2);           expect_out(16'd4, 1'b0, "R6 second half low");
      tk(2);           expect_out(16'd4, 1'b1, "R6 next period high");
      // R11: alias codes
      ld(3'd7, 16'd6); tk(1); expect_out(16'd4, 1'b1, "R11 code7 as square");
      ld(3'd6, 16'd2); tk(1); expect_out(16'd1, 1'b0, "R11 code6 as rate");
      // R8: mode 1 hardware trigger, R12 restart beats tick
      ld(3'd1, 16'd3); tk(2); expect_out(16'd3, 1'b1, "R8 waits for gate edge");
      gt(1'b0, 1'b0); gt(1'b1, 1'b1);
      expect_out(16'd3, 1'b0, "R12 restart over tick");
      tk(3);          expect_out(16'd0, 1'b1, "R8 out high at zero");
      gt(1'b0, 1'b1); expect_out(16'hFFFF, 1'b1, "R7 mode1 ignores gate level");
      // R10: mode 5 strobe
      ld(3'd5, 16'd2); gt(1'b1, 1'b0); expect_out(16'd2, 1'b1, "R8 mode5 triggered");
      tk(1);          expect_out(16'd1, 1'b1, "R10 before strobe");
      tk(1);          expect_out(16'd0, 1'b0, "R10 strobe low");
      gt(1'b1, 1'b0); expect_out(16'd0, 1'b0, "R10 strobe held to next tick");
      tk(1);          expect_out(16'hFFFF, 1'b1, "R10 strobe ends");
      ld(3'd4, 16'd1); tk(1); expect_out(16'd0, 1'b0, "R10 mode4 strobe");
      tk(1);                  expect_out(16'hFFFF, 1'b1, "R10 mode4 single strobe");
      // R9: restart in mode 2, none in mode 4
      ld(3'd2, 16'd5); tk(2); expect_out(16'd3, 1'b1, "R5 counting");
      gt(1'b0, 1'b0); gt(1'b1, 1'b0); expect_out(16'd5, 1'b1, "R9 mode2 restart");
      ld(3'd4, 16'd5); tk(1);
      gt(1'b0, 1'b0); gt(1'b1, 1'b0); expect_out(16'd4, 1'b1, "R9 mode4 no restart");
      // R12: load beats gate edge and tick
      gt(1'b0, 1'b0);
      step(1'b1, 1'b1, 1'b1, 3'd2, 16'd7); expect_out(16'd7, 1'b1, "R12 load wins");
      // R2: zero as full range
      ld(3'd2, 16'd0); expect_out(16'd0, 1'b1, "R2 zero loaded");
      tk(1);           expect_out(16'hFFFF, 1'b1, "R2 zero full range rate");
      ld(3'd3, 16'd0); tk(1); expect_out(16'hFFFE, 1'b1, "R2 zero full range square");
      @(negedge clk); @(negedge clk);
      if (exp_q.size() != 0) begin
         n_checks++; n_fail++;
         $display("FAIL scoreboard: %0d items left, expected 0", exp_q.size());
      end
      finish_run();
   end

endmodule